// File: doc/BRIEF.md
# UART Prioritized Interrupt Identifier

This block gathers the interrupt conditions of one UART channel and tells the host which pending condition is most urgent. There are five sources: receiver line status, receive data ready, receive character timeout, transmit holding register empty and modem status. The logic that owns each source raises it with a one-cycle set strobe and retires it with a one-cycle clear strobe. The block keeps a pending bit per source. The transmit-empty source can also be retired by the block itself.

A 4-bit enable register, written by the host, gates the sources onto the combined interrupt output and into the identification code. The code always names only the single highest-priority source that is both pending and enabled. The host services that source, and only then does the code move on to the next one.

Top module: `uart_irq_ident`

## Requirements
- R1: Enable register bit 0 gates both receive data ready and receive timeout, bit 1 gates transmit empty, bit 2 gates receiver line status and bit 3 gates modem status. A write takes effect after the clock edge it is sampled on. On read-back, bits 7..4 are always zero.
- R2: Reset is asynchronous and active low. It clears the enable register and every pending bit, so the read-back is 0x00, the code is 0001 and the interrupt output is low.
- R3: An enabled, pending receiver line status source is reported as code 0110 over every other source.
- R4: Receive timeout (code 1100) and receive data ready (code 0100) share the second priority level. When both are pending and enabled, the timeout is reported.
- R5: Transmit empty (code 0010) is reported below the receive sources, and modem status (code 0000) is reported lowest of all.
- R6: When no enabled source is pending, the code is 0001. Code bit 0 is low exactly when an interrupt is pending.
- R7: The interrupt output is high when any enabled source is pending. It goes low on the clock edge that clears or masks the last one.
- R8: A source that is masked keeps its pending state. It is reported as soon as its enable bit is set.
- R9: A pending transmit-empty source is cleared by an identification read whose code is 0010, or by a transmit holding register write. An identification read that reports a different code leaves it pending.
- R10: When a set and a clear of the same source arrive in the same cycle, the source is left pending.
- R11: A clear strobe on one source, given by its vector bit (0 line status, 1 data ready, 2 timeout, 3 transmit empty, 4 modem status), retires that source on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ier_wr | input | 1 | Enable register write strobe |
| ier_wdata | input | 8 | Enable register write data |
| ier_rdata | output | 8 | Enable register read-back |
| iir_rd | input | 1 | Identification register read strobe |
| thr_wr | input | 1 | Transmit holding register write strobe |
| src_set | input | 5 | Per-source set strobes (bit map as in R11) |
| src_clr | input | 5 | Per-source clear strobes (bit map as in R11) |
| iir_code | output | 4 | Identification code of the highest pending enabled source |
| irq_o | output | 1 | Combined interrupt output |

## Verification
The assertions check several properties on every cycle. The interrupt output must agree with code bit 0, and the line status source must win whenever it is active. Each set or clear strobe must land on its pending bit one edge later. A write must appear on the enable read-back, with the upper bits at zero, and a read that reports transmit empty must retire it. Only the bench's scenarios can show the full priority order and the split within the second level. They also show masked sources waiting and then reappearing, and the reset state both after start-up and after a reset in the middle of a run.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
    localparam int NSRC  = 5;
    localparam int S_LSR = 0;
    localparam int S_RXD = 1;
    localparam int S_TMO = 2;
    localparam int S_TXE = 3;
    localparam int S_MSR = 4;

    localparam int E_RXD = 0;
    localparam int E_TXE = 1;
    localparam int E_LSR = 2;
    localparam int E_MSR = 3;

    typedef logic [3:0] irq_code_t;
    localparam irq_code_t C_LSR  = 4'b0110;
    localparam irq_code_t C_RXD  = 4'b0100;
    localparam irq_code_t C_TMO  = 4'b1100;
    localparam irq_code_t C_TXE  = 4'b0010;
    localparam irq_code_t C_MSR  = 4'b0000;
    localparam irq_code_t C_NONE = 4'b0001;
endpackage

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
    parameter int REG_W = 8,
    parameter int ENB_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    output logic [ENB_W-1:0] en,
    output logic [REG_W-1:0] rdata
);
    localparam logic [REG_W-1:0] ENB_MASK = REG_W'((1 << ENB_W) - 1);

    typedef struct packed {
        logic [ENB_W-1:0] en;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) begin
            st_d.en = ENB_W'(wdata & ENB_MASK);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en    = st_q.en;
    assign rdata = REG_W'(st_q.en);

    // R1: a write shows on the read-back, upper bits zero
    a_r1_write_readback: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (rdata[ENB_W-1:0] == $past(wdata[ENB_W-1:0])) &&
               (rdata[REG_W-1:ENB_W] == '0));
endmodule

// File: rtl/irq_pending.sv
module irq_pending #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] pend
);
    typedef struct packed {
        logic [N-1:0] pend;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // set wins over clear in the same cycle
        st_d.pend = (st_q.pend & ~clr) | set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend = st_q.pend;

    for (genvar i = 0; i < N; i++) begin : g_chk
        // R11: a lone clear retires the source
        a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[i] && !set[i]) |=> !pend[i]);
        // R10: a set always leaves the source pending
        a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            set[i] |=> pend[i]);
    end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
    import uart_irq_pkg::*;
(
    input  logic [NSRC-1:0] act,
    output irq_code_t       code
);
    always_comb begin
        if      (act[S_LSR]) code = C_LSR;
        else if (act[S_TMO]) code = C_TMO;
        else if (act[S_RXD]) code = C_RXD;
        else if (act[S_TXE]) code = C_TXE;
        else if (act[S_MSR]) code = C_MSR;
        else                 code = C_NONE;
    end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_pkg::*;
#(
    parameter int REG_W = 8,
    parameter int ENB_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ier_wr,
    input  logic [REG_W-1:0] ier_wdata,
    output logic [REG_W-1:0] ier_rdata,
    input  logic             iir_rd,
    input  logic             thr_wr,
    input  logic [NSRC-1:0]  src_set,
    input  logic [NSRC-1:0]  src_clr,
    output logic [3:0]       iir_code,
    output logic             irq_o
);
    logic [ENB_W-1:0] en;
    logic [NSRC-1:0]  src_en;
    logic [NSRC-1:0]  pend;
    logic [NSRC-1:0]  act;
    logic [NSRC-1:0]  clr_all;
    irq_code_t        code;
    logic             txe_self_clr;

    irq_enable_reg #(.REG_W(REG_W), .ENB_W(ENB_W)) u_enable (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (ier_wr),
        .wdata (ier_wdata),
        .en    (en),
        .rdata (ier_rdata)
    );

    always_comb begin
        src_en         = '0;
        src_en[S_LSR]  = en[E_LSR];
        src_en[S_RXD]  = en[E_RXD];
        src_en[S_TMO]  = en[E_RXD];
        src_en[S_TXE]  = en[E_TXE];
        src_en[S_MSR]  = en[E_MSR];
    end

    assign txe_self_clr = thr_wr || (iir_rd && (code == C_TXE));

    always_comb begin
        clr_all        = src_clr;
        clr_all[S_TXE] = src_clr[S_TXE] | txe_self_clr;
    end

    irq_pending #(.N(NSRC)) u_pend (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (src_set),
        .clr   (clr_all),
        .pend  (pend)
    );

    assign act = pend & src_en;

    irq_prio_enc u_enc (
        .act  (act),
        .code (code)
    );

    assign iir_code = code;
    assign irq_o    = |act;

    // R6 / R7: output and code bit 0 agree
    a_r6_irq_vs_code: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == !iir_code[0]);
    // R3: line status wins whenever active
    a_r3_lsr_top: assert property (@(posedge clk) disable iff (!rst_n)
        (pend[S_LSR] && en[E_LSR]) |-> (iir_code == C_LSR));
    // R9: a read reporting transmit empty retires it
    a_r9_txe_read_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (iir_rd && (iir_code == C_TXE) && !src_set[S_TXE]) |=> !pend[S_TXE]);
    // R9: a holding register write retires transmit empty
    a_r9_txe_write_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_wr && !src_set[S_TXE]) |=> !pend[S_TXE]);
endmodule

// File: tb/tb_uart_irq_ident.sv
module tb_uart_irq_ident;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ier_wr = 1'b0;
    logic [7:0] ier_wdata = '0;
    logic [7:0] ier_rdata;
    logic       iir_rd = 1'b0;
    logic       thr_wr = 1'b0;
    logic [4:0] src_set = '0;
    logic [4:0] src_clr = '0;
    logic [3:0] iir_code;
    logic       irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [3:0] code;
        logic       irq;
        logic [7:0] ier;
        string      tag;
    } exp_t;

    exp_t sb[$];

    always #4 clk = ~clk;

    uart_irq_ident dut (
        .clk(clk), .rst_n(rst_n), .ier_wr(ier_wr), .ier_wdata(ier_wdata),
        .ier_rdata(ier_rdata), .iir_rd(iir_rd), .thr_wr(thr_wr),
        .src_set(src_set), .src_clr(src_clr), .iir_code(iir_code), .irq_o(irq_o)
    );

    // source bits: 0 lsr, 1 rx data, 2 timeout, 3 tx empty, 4 modem
    task automatic step(input logic rs, input logic [4:0] s, input logic [4:0] c,
                        input logic w, input logic [7:0] wd, input logic rd,
                        input logic tw, input logic [3:0] ec, input logic ei,
                        input logic [7:0] eier, input string tag);
        exp_t e;
        @(negedge clk);
        rst_n = ~rs; src_set = s; src_clr = c; ier_wr = w; ier_wdata = wd;
        iir_rd = rd; thr_wr = tw;
        e.code = ec; e.irq = ei; e.ier = eier; e.tag = tag;
        sb.push_back(e);
    endtask

    always @(posedge clk) begin
        #2;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (iir_code !== e.code || irq_o !== e.irq || ier_rdata !== e.ier) begin
                errors++;
                $display("FAIL %s: code=%b irq=%b ier=%h expected code=%b irq=%b ier=%h",
                         e.tag, iir_code, irq_o, ier_rdata, e.code, e.irq, e.ier);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        step(1, 5'h00, 5'h00, 0, 8'h00, 0, 0, 4'b0001, 0, 8'h00, "R2 reset state");
        step(0, 5'h00, 5'h00, 0, 8'h00, 0, 0, 4'b0001, 0, 8'h00, "R6 idle code");
        step(0, 5'h1F, 5'h00, 0, 8'h00, 0, 0, 4'b0001, 0, 8'h00, "R8 all masked");
        step(0, 5'h00, 5'h00, 1, 8'hFF, 0, 0, 4'b0110, 1, 8'h0F, "R1 R3 enable all, lsr first");
        step(0, 5'h00, 5'h01, 0, 8'h00, 0, 0, 4'b1100, 1, 8'h0F, "R4 timeout over data ready");
        step(0, 5'h00, 5'h04, 0, 8'h00, 0, 0, 4'b0100, 1, 8'h0F, "R4 data ready");
        step(0, 5'h00, 5'h02, 0, 8'h00, 0, 0, 4'b0010, 1, 8'h0F, "R5 tx empty");
        step(0, 5'h00, 5'h00, 0, 8'h00, 1, 0, 4'b0000, 1, 8'h0F, "R9 read clears tx, R5 modem");
        step(0, 5'h00, 5'h10, 0, 8'h00, 0, 0, 4'b0001, 0, 8'h0F, "R7 last clear drops irq");
        step(0, 5'h08, 5'h00, 0, 8'h00, 0, 0, 4'b0010, 1, 8'h0F, "R5 tx set");
        step(0, 5'h00, 5'h00, 0, 8'h00, 0, 1, 4'b0001, 0, 8'h0F, "R9 thr write clears tx");
        step(0, 5'h19, 5'h00, 0, 8'h00, 0, 0, 4'b0110, 1, 8'h0F, "R3 lsr over tx and modem");
        step(0, 5'h00, 5'h00, 0, 8'h00, 1, 0, 4'b0110, 1, 8'h0F, "R9 read of lsr keeps tx");
        step(0, 5'h00, 5'h00, 1, 8'h02, 0, 0, 4'b0010, 1, 8'h02, "R1 bit1 tx only");
        step(0, 5'h00, 5'h00, 1, 8'h08, 0, 0, 4'b0000, 1, 8'h08, "R1 bit3 modem only");
        step(0, 5'h00, 5'h00, 1, 8'h00, 0, 0, 4'b0001, 0, 8'h00, "R7 masking drops irq");
        step(0, 5'h00, 5'h00, 1, 8'hF4, 0, 0, 4'b0110, 1, 8'h04, "R1 bit2 lsr, upper zero");
        step(0, 5'h00, 5'h01, 0, 8'h00, 0, 0, 4'b0001, 0, 8'h04, "R11 lsr clear");
        step(0, 5'h01, 5'h01, 0, 8'h00, 0, 0, 4'b0110, 1, 8'h04, "R10 set wins over clear");
        step(0, 5'h02, 5'h01, 1, 8'h01, 0, 0, 4'b0100, 1, 8'h01, "R1 bit0 data ready");
        step(0, 5'h04, 5'h00, 0, 8'h00, 0, 0, 4'b1100, 1, 8'h01, "R1 bit0 gates timeout");
        step(0, 5'h00, 5'h00, 0, 8'h00, 1, 0, 4'b1100, 1, 8'h01, "R9 read of timeout no clear");
        step(0, 5'h00, 5'h06, 1, 8'h02, 0, 0, 4'b0010, 1, 8'h02, "R8 tx still pending");
        step(0, 5'h08, 5'h00, 0, 8'h00, 0, 1, 4'b0010, 1, 8'h02, "R10 tx set wins over thr write");
        step(0, 5'h00, 5'h00, 0, 8'h00, 0, 1, 4'b0001, 0, 8'h02, "R9 thr write clears tx");
        step(0, 5'h10, 5'h00, 1, 8'h08, 0, 0, 4'b0000, 1, 8'h08, "R5 modem alone");
        step(1, 5'h00, 5'h00, 0, 8'h00, 0, 0, 4'b0001, 0, 8'h00, "R2 mid-run reset");
        step(0, 5'h00, 5'h00, 1, 8'h0F, 0, 0, 4'b0001, 0, 8'h0F, "R2 pending cleared by reset");
        step(0, 5'h00, 5'h00, 0, 8'h00, 0, 0, 4'b0001, 0, 8'h0F, "R6 idle after reset");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule